// File: doc/BRIEF.md
# Paired Instruction Fetch Enqueue Unit

This block collects instructions coming out of an instruction cache and stores them in a small fetch queue for the core. A cache hit carries one 32-bit instruction and its address. A line fill after a miss carries 64-bit beats, each holding two instructions. A 2-bit lane select with each beat decides whether the beat adds nothing, only its low word, only its high word, or both words. A single cycle can therefore add zero, one or two queue entries. Each entry holds the instruction, its address and the fetch epoch that was current when it was written.

The core takes entries through a valid/ready pair. The oldest entry is always shown. A flush empties the queue in one cycle and loads a new epoch value, so anything fetched after the redirect can be told apart from stale fetches. The upstream side sees one `in_ready` signal, which promises room for a full two-word beat.

Top module: `fetch_pair_enq`

## Requirements
- R1: A hit (`hit_valid` high) that is accepted adds one entry holding `hit_pc`, `hit_instr` and the current epoch.
- R2: An accepted fill beat with select 2'b00 adds no entry.
- R3: An accepted fill beat with select 2'b01 adds one entry: instruction `fill_data[31:0]`, address `fill_pc`.
- R4: An accepted fill beat with select 2'b10 adds one entry: instruction `fill_data[63:32]`, address `fill_pc + 4`.
- R5: An accepted fill beat with select 2'b11 adds two entries, the low word at `fill_pc` first and then the high word at `fill_pc + 4`.
- R6: When `hit_valid` and `fill_valid` are both high, only the hit is taken and the fill beat has no effect.
- R7: `in_ready` is high exactly when at least two of the DEPTH slots are free. An input is accepted only when `in_ready` is high and `flush` is low. Otherwise it is dropped.
- R8: While `flush` is high, the queue is empty from the next cycle on and the epoch becomes `flush_epoch`. Entries written later carry that epoch.
- R9: `out_valid` is high whenever the queue is non-empty. The outputs show the oldest entry. An entry leaves on a cycle when `out_valid` and `out_ready` are both high, and entries leave in the order they were written.
- R10: A pop and a two-entry push in the same cycle are both carried out.
- R11: After reset the queue is empty (`out_valid` low), `in_ready` is high and the epoch is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hit_valid | input | 1 | Single instruction from a cache hit is present |
| hit_instr | input | 32 | Hit instruction |
| hit_pc | input | ADDR_W | Hit instruction address |
| fill_valid | input | 1 | Fill beat is present |
| fill_data | input | 64 | Two instructions: low word at bits 31:0, high word at bits 63:32 |
| fill_pc | input | ADDR_W | Address of the low word of the beat |
| fill_sel | input | 2 | Lane select: 00 none, 01 low, 10 high, 11 both |
| in_ready | output | 1 | At least two slots are free |
| flush | input | 1 | Empty the queue and load a new epoch |
| flush_epoch | input | EPOCH_W | Epoch value loaded on flush |
| out_valid | output | 1 | Queue holds an entry |
| out_ready | input | 1 | Core takes the shown entry |
| out_instr | output | 32 | Oldest entry's instruction |
| out_pc | output | ADDR_W | Oldest entry's address |
| out_epoch | output | EPOCH_W | Oldest entry's epoch |

## Verification
The bench builds the block with its defaults: DEPTH 8, a 32-bit address and a 3-bit epoch. The queue is shallow enough that a short run of two-word beats with the consumer stalled hits the `in_ready` boundary many times. The bench sweeps every lane select against stalled and draining consumers, hit/fill collisions, and flushes at several fill levels. This covers every wrap of the 3-bit pointers and every fill level from empty to full.

// File: rtl/fpe_pkg.sv
package fpe_pkg;
    localparam int INSTR_W = 32;
    localparam int BEAT_W  = 2 * INSTR_W;

    typedef enum logic [1:0] {
        LANE_NONE = 2'b00,
        LANE_LO   = 2'b01,
        LANE_HI   = 2'b10,
        LANE_BOTH = 2'b11
    } lane_sel_e;
endpackage

// File: rtl/fpe_lane_pick.sv
module fpe_lane_pick
    import fpe_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int EPOCH_W = 3,
    localparam int ENT_W  = ADDR_W + INSTR_W + EPOCH_W
) (
    input  logic               accept,
    input  logic               hit_valid,
    input  logic [INSTR_W-1:0] hit_instr,
    input  logic [ADDR_W-1:0]  hit_pc,
    input  logic               fill_valid,
    input  logic [BEAT_W-1:0]  fill_data,
    input  logic [ADDR_W-1:0]  fill_pc,
    input  logic [1:0]         fill_sel,
    input  logic [EPOCH_W-1:0] epoch,
    output logic [1:0]         n_push,
    output logic [ENT_W-1:0]   ent0,
    output logic [ENT_W-1:0]   ent1
);
    logic [INSTR_W-1:0] lo_word;
    logic [INSTR_W-1:0] hi_word;
    logic [ADDR_W-1:0]  hi_pc;

    assign lo_word = fill_data[INSTR_W-1:0];
    assign hi_word = fill_data[BEAT_W-1:INSTR_W];
    assign hi_pc   = fill_pc + ADDR_W'(INSTR_W / 8);

    always_comb begin
        n_push = 2'd0;
        ent0   = '0;
        ent1   = '0;
        if (accept) begin
            if (hit_valid) begin
                n_push = 2'd1;
                ent0   = {hit_pc, hit_instr, epoch};
            end else if (fill_valid) begin
                unique case (lane_sel_e'(fill_sel))
                    LANE_NONE: n_push = 2'd0;
                    LANE_LO: begin
                        n_push = 2'd1;
                        ent0   = {fill_pc, lo_word, epoch};
                    end
                    LANE_HI: begin
                        n_push = 2'd1;
                        ent0   = {hi_pc, hi_word, epoch};
                    end
                    LANE_BOTH: begin
                        n_push = 2'd2;
                        ent0   = {fill_pc, lo_word, epoch};
                        ent1   = {hi_pc, hi_word, epoch};
                    end
                    default: n_push = 2'd0;
                endcase
            end
        end
    end
endmodule

// File: rtl/fpe_ring.sv
module fpe_ring #(
    parameter int ENT_W  = 67,
    parameter int DEPTH  = 8,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic [1:0]       n_push,
    input  logic [ENT_W-1:0] ent0,
    input  logic [ENT_W-1:0] ent1,
    input  logic             pop,
    output logic [ENT_W-1:0] head,
    output logic [CNT_W-1:0] count
);
    typedef struct packed {
        logic [DEPTH-1:0][ENT_W-1:0] mem;
        logic [PTR_W-1:0]            wr;
        logic [PTR_W-1:0]            rd;
        logic [CNT_W-1:0]            cnt;
    } ring_t;

    ring_t ring_d, ring_q;
    logic  do_pop;

    assign do_pop = pop && (ring_q.cnt != '0);

    always_comb begin
        ring_d = ring_q;
        if (clear) begin
            ring_d.wr  = '0;
            ring_d.rd  = '0;
            ring_d.cnt = '0;
        end else begin
            if (n_push != 2'd0) begin
                ring_d.mem[ring_q.wr] = ent0;
            end
            if (n_push == 2'd2) begin
                ring_d.mem[ring_q.wr + PTR_W'(1)] = ent1;
            end
            ring_d.wr  = ring_q.wr + PTR_W'(n_push);
            ring_d.rd  = ring_q.rd + PTR_W'(do_pop);
            ring_d.cnt = ring_q.cnt + CNT_W'(n_push) - CNT_W'(do_pop);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ring_q <= '0;
        end else begin
            ring_q <= ring_d;
        end
    end

    assign head  = ring_q.mem[ring_q.rd];
    assign count = ring_q.cnt;
endmodule

// File: rtl/fetch_pair_enq.sv
module fetch_pair_enq
    import fpe_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int EPOCH_W = 3,
    parameter int DEPTH   = 8,
    localparam int ENT_W  = ADDR_W + INSTR_W + EPOCH_W,
    localparam int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               hit_valid,
    input  logic [31:0]        hit_instr,
    input  logic [ADDR_W-1:0]  hit_pc,
    input  logic               fill_valid,
    input  logic [63:0]        fill_data,
    input  logic [ADDR_W-1:0]  fill_pc,
    input  logic [1:0]         fill_sel,
    output logic               in_ready,
    input  logic               flush,
    input  logic [EPOCH_W-1:0] flush_epoch,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [31:0]        out_instr,
    output logic [ADDR_W-1:0]  out_pc,
    output logic [EPOCH_W-1:0] out_epoch
);
    typedef struct packed {
        logic [EPOCH_W-1:0] epoch;
    } ctl_t;

    ctl_t             ctl_d, ctl_q;
    logic             accept;
    logic [1:0]       n_push;
    logic [ENT_W-1:0] ent0, ent1, head;
    logic [CNT_W-1:0] occ;

    assign in_ready  = (occ <= CNT_W'(DEPTH - 2));
    assign accept    = in_ready && !flush;
    assign out_valid = (occ != '0);

    always_comb begin
        ctl_d = ctl_q;
        if (flush) begin
            ctl_d.epoch = flush_epoch;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    fpe_lane_pick #(.ADDR_W(ADDR_W), .EPOCH_W(EPOCH_W)) u_pick (
        .accept    (accept),
        .hit_valid (hit_valid),
        .hit_instr (hit_instr),
        .hit_pc    (hit_pc),
        .fill_valid(fill_valid),
        .fill_data (fill_data),
        .fill_pc   (fill_pc),
        .fill_sel  (fill_sel),
        .epoch     (ctl_q.epoch),
        .n_push    (n_push),
        .ent0      (ent0),
        .ent1      (ent1)
    );

    fpe_ring #(.ENT_W(ENT_W), .DEPTH(DEPTH)) u_ring (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (flush),
        .n_push(n_push),
        .ent0  (ent0),
        .ent1  (ent1),
        .pop   (out_valid && out_ready),
        .head  (head),
        .count (occ)
    );

    assign {out_pc, out_instr, out_epoch} = head;
endmodule

// File: rtl/fpe_checker.sv
module fpe_checker #(
    parameter int DEPTH  = 8,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             flush,
    input logic             in_ready,
    input logic             out_valid,
    input logic             out_ready,
    input logic             hit_valid,
    input logic             fill_valid,
    input logic [1:0]       fill_sel,
    input logic [CNT_W-1:0] occ
);
    logic pop, take;
    assign pop  = out_valid && out_ready;
    assign take = in_ready && !flush;

    a_r7_ready_room: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> (occ <= CNT_W'(DEPTH - 2)));

    a_r8_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !out_valid);

    a_r1_hit_adds_one: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_valid && take && !pop) |=> (occ == $past(occ) + CNT_W'(1)));

    a_r5_both_adds_two: assert property (@(posedge clk) disable iff (!rst_n)
        (!hit_valid && fill_valid && fill_sel == 2'b11 && take && !pop)
        |=> (occ == $past(occ) + CNT_W'(2)));

    a_r2_none_adds_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (!hit_valid && fill_valid && fill_sel == 2'b00 && !flush && !pop)
        |=> $stable(occ));

    a_r9_pop_removes_one: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !flush && !hit_valid && !fill_valid)
        |=> (occ == $past(occ) - CNT_W'(1)));
endmodule

bind fetch_pair_enq fpe_checker #(.DEPTH(DEPTH)) u_fpe_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (flush),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .hit_valid (hit_valid),
    .fill_valid(fill_valid),
    .fill_sel  (fill_sel),
    .occ       (occ)
);

// File: tb/fetch_pair_enq_test.sv
module fetch_pair_enq_test;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hit_valid = 1'b0;
    logic [31:0] hit_instr = '0;
    logic [31:0] hit_pc = '0;
    logic        fill_valid = 1'b0;
    logic [63:0] fill_data = '0;
    logic [31:0] fill_pc = '0;
    logic [1:0]  fill_sel = '0;
    logic        in_ready;
    logic        flush = 1'b0;
    logic [2:0]  flush_epoch = '0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [31:0] out_instr;
    logic [31:0] out_pc;
    logic [2:0]  out_epoch;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [31:0] m_pc [64];
    logic [31:0] m_in [64];
    logic [2:0]  m_ep [64];
    int m_head = 0, m_tail = 0;
    logic [2:0] m_epoch = '0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    fetch_pair_enq #(.ADDR_W(32), .EPOCH_W(3), .DEPTH(DEPTH)) uut (
        .clk(clk), .rst_n(rst_n),
        .hit_valid(hit_valid), .hit_instr(hit_instr), .hit_pc(hit_pc),
        .fill_valid(fill_valid), .fill_data(fill_data), .fill_pc(fill_pc),
        .fill_sel(fill_sel), .in_ready(in_ready),
        .flush(flush), .flush_epoch(flush_epoch),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_instr(out_instr), .out_pc(out_pc), .out_epoch(out_epoch)
    );

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic push_m(input logic [31:0] pc, input logic [31:0] ins);
        m_pc[m_tail % 64] = pc;
        m_in[m_tail % 64] = ins;
        m_ep[m_tail % 64] = m_epoch;
        m_tail++;
    endtask

    // Called just after a falling edge: drive, check, advance one clock.
    task automatic step(input string tag, input bit hv, input logic [31:0] hp,
                        input logic [31:0] hi, input bit fv, input logic [31:0] fp,
                        input logic [63:0] fd, input logic [1:0] fs,
                        input bit fl, input logic [2:0] fe, input bit ordy);
        int cnt;
        bit e_rdy, e_val, acc;
        hit_valid = hv; hit_pc = hp; hit_instr = hi;
        fill_valid = fv; fill_pc = fp; fill_data = fd; fill_sel = fs;
        flush = fl; flush_epoch = fe; out_ready = ordy;
        #1;
        cnt   = m_tail - m_head;
        e_rdy = (DEPTH - cnt) >= 2;
        e_val = cnt > 0;
        check(tag, "in_ready R7", 32'(in_ready), 32'(e_rdy));
        check(tag, "out_valid R9", 32'(out_valid), 32'(e_val));
        if (e_val) begin
            check(tag, "out_pc R9", out_pc, m_pc[m_head % 64]);
            check(tag, "out_instr R9", out_instr, m_in[m_head % 64]);
            check(tag, "out_epoch R8", 32'(out_epoch), 32'(m_ep[m_head % 64]));
        end
        acc = e_rdy && !fl;
        if (fl) begin
            m_head  = m_tail;
            m_epoch = fe;
        end else begin
            if (e_val && ordy) m_head++;
            if (acc) begin
                if (hv) push_m(hp, hi);
                else if (fv) begin
                    if (fs[0]) push_m(fp, fd[31:0]);
                    if (fs[1]) push_m(fp + 32'd4, fd[63:32]);
                end
            end
        end
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle(input string tag, input bit ordy);
        step(tag, 0, '0, '0, 0, '0, '0, 2'b00, 0, '0, ordy);
    endtask

    task automatic fill(input string tag, input int k, input logic [1:0] s, input bit ordy);
        step(tag, 0, '0, '0, 1, 32'(k) * 8, {32'hB000_0000 + 32'(k), 32'hA000_0000 + 32'(k)},
             s, 0, '0, ordy);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int k = 0;
        @(negedge clk);
        @(negedge clk);
        // R11: reset state
        check("R11", "out_valid", 32'(out_valid), 0);
        check("R11", "in_ready", 32'(in_ready), 1);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: single hits, stalled, then drain
        for (int i = 0; i < 3; i++)
            step("R1", 1, 32'h100 + 32'(i) * 4, 32'hC000_0000 + 32'(i), 0, '0, '0, 2'b00, 0, '0, 0);
        for (int i = 0; i < 4; i++) idle("R9", 1);

        // R2..R5: every select code against stalled and draining consumers
        for (int s = 0; s < 4; s++) begin
            for (int r = 0; r < 2; r++) begin
                for (int n = 0; n < 6; n++) begin
                    fill(s == 0 ? "R2" : s == 1 ? "R3" : s == 2 ? "R4" : "R5",
                         k, 2'(s), r[0]);
                    k++;
                end
                for (int n = 0; n < 10; n++) idle("R9", 1);
            end
        end

        // R7: fill to full with stalled consumer; extra beats dropped
        for (int n = 0; n < 7; n++) begin fill("R7", k, 2'b11, 0); k++; end
        idle("R7", 0);
        // R10: pop and two-entry push in the same cycle, from several levels
        for (int n = 0; n < 12; n++) begin fill("R10", k, 2'b11, 1); k++; end
        for (int n = 0; n < 10; n++) idle("R9", 1);

        // R6: hit and fill together, only hit taken
        for (int n = 0; n < 3; n++) begin
            step("R6", 1, 32'h4000 + 32'(n) * 4, 32'hD000_0000 + 32'(n), 1, 32'h8000,
                 64'hEEEE_EEEE_FFFF_FFFF, 2'b11, 0, '0, 0);
        end

        // R8: flush at several fill levels, new epoch, input dropped during flush
        for (int e = 1; e < 8; e++) begin
            for (int n = 0; n < e % 4; n++) begin fill("R8", k, 2'b11, 0); k++; end
            step("R8", 1, 32'h9000, 32'h1234_5678, 0, '0, '0, 2'b00, 1, 3'(e), 0);
            step("R8", 0, '0, '0, 1, 32'h7000, {32'h2, 32'h1}, 2'b11, 0, '0, 0);
            idle("R8", 1);
            idle("R8", 1);
            idle("R8", 1);
        end
        for (int n = 0; n < 4; n++) idle("R9", 1);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule